// File: doc/BRIEF.md
# Bus Packet Error Check Engine

This block computes an 8-bit CRC over every bit that a two-wire serial bus controller moves, and turns that CRC into the packet error check of a transaction. The controller gives it one strobe per data bit with the bit value, most significant bit first. This covers the address byte with its read/write bit and every data byte. The acknowledge slot is not fed. After the eighth bit the controller pulses a byte boundary. A START condition returns the CRC to its initial value.

When the controller transmits, a check request (from software or from a DMA end-of-transfer) makes the engine hand over the CRC as the next byte to send, right after the byte in progress. When the controller receives, a check request or the DMA one-before-last indication marks the byte after the current one as the check byte. Once that byte has been absorbed, a correct check leaves the CRC at zero. Any other value, or a CRC spoiled by a lost arbitration, raises the error flag. The engine gives the acknowledge decision for every received byte and forces a NACK where the master-receive rules need one.

Top module: `bus_pec_engine`

## Requirements
- R1: After reset and after every START pulse, the CRC is 0x00, the CRC is valid and the error flag is clear. START also cancels any pending check in either direction.
- R2: On each bit strobe while calculation is enabled, the CRC shifts left by one. If the old top bit XOR the bus bit is 1, the result is XORed with the polynomial. The address and read/write bits count like any other bit.
- R3: While calculation is disabled, bit strobes leave the CRC unchanged.
- R4: The polynomial is taken from the poly input, which supplies the low 8 coefficients. The x^8 term is implied. The default use is 0x07.
- R5: In transmit, a check request seen during a byte produces a one-cycle chk_load pulse in the cycle after that byte's boundary. chk_byte then holds the CRC over all bits up to that boundary.
- R6: In transmit, the DMA end-of-transfer indication acts the same way as a check request.
- R7: In receive, a check request or the DMA one-before-last indication during byte N makes byte N+1 the check byte. A slave ACKs a matching check byte and leaves the error flag clear.
- R8: In receive, a check byte that does not match sets the error flag, and a slave NACKs it. The flag stays set until the next START.
- R9: In master-receive, the check byte is always NACKed, whatever the result of the comparison.
- R10: dma_req pulses together with the acknowledge strobe of a check byte, and never for an ordinary byte.
- R11: An arbitration-loss pulse makes crc_valid low until the next START. A check made while the CRC is invalid counts as a mismatch.
- R12: In master-receive, the DMA end-of-transfer seen during a byte while last_xfer is 1 makes that byte NACKed. With last_xfer at 0 the byte is ACKed.
- R13: In receive, ack_stb pulses for one cycle after every byte boundary, and nack is valid with it. In transmit, ack_stb stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calc_en | input | 1 | CRC calculation enable |
| poly | input | 8 | Polynomial coefficients x^7..x^0 |
| start_det | input | 1 | START condition pulse |
| bit_stb | input | 1 | One data bit moved on the bus |
| bit_val | input | 1 | Value of that bit |
| byte_end | input | 1 | Byte boundary pulse, after the eighth bit strobe |
| dir_tx | input | 1 | 1 = controller transmits, 0 = receives |
| role_master | input | 1 | 1 = controller is bus master |
| chk_req | input | 1 | Software check request |
| dma_eot | input | 1 | DMA end-of-transfer |
| dma_eot_m1 | input | 1 | DMA one-before-last transfer |
| last_xfer | input | 1 | Last-transfer control bit |
| arb_lost | input | 1 | Arbitration-loss pulse |
| crc_value | output | 8 | Running CRC |
| crc_valid | output | 1 | CRC not spoiled since START |
| chk_load | output | 1 | Load chk_byte as the next byte to transmit |
| chk_byte | output | 8 | Check byte to transmit |
| chk_err | output | 1 | Sticky check mismatch flag |
| ack_stb | output | 1 | Acknowledge decision strobe (receive) |
| nack | output | 1 | 1 = NACK the byte, valid with ack_stb |
| dma_req | output | 1 | DMA request after a check byte |

## Verification
The CRC is compared with a bit-serial model for several byte streams that start with an address byte. Two polynomials are used, which separates a wrong shift direction or feedback tap from a fixed constant. A disabled-calculation byte tests that the strobe gating is kept. Receive checks pair a correct check byte with one that differs in a single bit. They run under slave, master and arbitration-loss conditions, which tells the comparison apart from the forced NACK rules. Transmit runs show whether the check byte comes after the right boundary for both trigger sources. The last-transfer pair shows the difference between a DMA end-of-transfer with the control bit set and the same transfer without it.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ARMED,
        RX_CHECK
    } rx_state_e;

    typedef struct packed {
        logic stb;
        logic nack;
        logic chk;
    } rx_verdict_t;

    function automatic crc_t crc_step(input crc_t cur, input logic din, input crc_t p);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? p : '0);
    endfunction

endpackage

// File: rtl/pec_crc_core.sv
module pec_crc_core
    import pec_pkg::*;
#(
    parameter crc_t CRC_INIT = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic start_det,
    input  logic calc_en,
    input  crc_t poly,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic arb_lost,
    output crc_t crc_q,
    output logic valid_q
);

    always_ff @(posedge clk) begin
        if (rst || start_det) begin
            crc_q   <= CRC_INIT;
            valid_q <= 1'b1;
        end else begin
            if (calc_en && bit_stb)
                crc_q <= crc_step(crc_q, bit_val, poly);
            if (arb_lost)
                valid_q <= 1'b0;
        end
    end

    // R1: START restores the initial CRC and validity
    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (crc_q == CRC_INIT) && valid_q);

    // R3: no update while calculation is off
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!calc_en && !start_det) |=> $stable(crc_q));

    // R11: arbitration loss spoils the CRC until START
    a_r11_arb_invalid: assert property (@(posedge clk) disable iff (rst)
        (arb_lost && !start_det) |=> !valid_q);

    a_r11_invalid_sticky: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !start_det) |=> !valid_q);

endmodule

// File: rtl/pec_tx_ctrl.sv
module pec_tx_ctrl
    import pec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_det,
    input  logic calc_en,
    input  logic dir_tx,
    input  logic chk_req,
    input  logic dma_eot,
    input  logic byte_end,
    input  crc_t crc_in,
    output logic chk_load,
    output crc_t chk_byte
);

    logic pend_q;
    logic req_now;
    logic armed;

    assign req_now = calc_en && dir_tx && (chk_req || dma_eot);
    assign armed   = pend_q || req_now;

    always_ff @(posedge clk) begin
        if (rst || start_det) begin
            pend_q   <= 1'b0;
            chk_load <= 1'b0;
            chk_byte <= '0;
        end else begin
            chk_load <= byte_end && armed;
            if (byte_end && armed) begin
                chk_byte <= crc_in;
                pend_q   <= 1'b0;
            end else if (req_now) begin
                pend_q <= 1'b1;
            end
        end
    end

    // R5: check byte is handed over only right after a boundary
    a_r5_load_on_boundary: assert property (@(posedge clk) disable iff (rst)
        chk_load |-> $past(byte_end));

    // R5: a pending request is consumed by the boundary
    a_r5_pend_consumed: assert property (@(posedge clk) disable iff (rst)
        (byte_end && pend_q && !start_det) |=> chk_load && !pend_q);

endmodule

// File: rtl/pec_rx_ctrl.sv
module pec_rx_ctrl
    import pec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_det,
    input  logic calc_en,
    input  logic dir_tx,
    input  logic role_master,
    input  logic chk_req,
    input  logic dma_eot,
    input  logic dma_eot_m1,
    input  logic last_xfer,
    input  logic byte_end,
    input  crc_t crc_in,
    input  logic crc_valid,
    output logic ack_stb,
    output logic nack,
    output logic chk_err,
    output logic dma_req
);

    rx_state_e   state_q, state_d;
    rx_verdict_t verdict;
    logic        rx_mode, arm, final_q, final_set, final_now, is_chk, mism;

    assign rx_mode   = !dir_tx;
    assign arm       = calc_en && rx_mode && (chk_req || dma_eot_m1);
    assign final_set = dma_eot && last_xfer && rx_mode && role_master;
    assign final_now = final_q || final_set;
    assign is_chk    = (state_q == RX_CHECK);
    // a matching check byte brings the running CRC back to zero
    assign mism      = (crc_in != '0) || !crc_valid;

    always_comb begin
        state_d = state_q;
        case (state_q)
            RX_IDLE:  if (arm) state_d = byte_end ? RX_CHECK : RX_ARMED;
            RX_ARMED: if (byte_end) state_d = RX_CHECK;
            RX_CHECK: if (byte_end) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        verdict.stb  = byte_end && rx_mode;
        verdict.chk  = verdict.stb && is_chk;
        verdict.nack = verdict.stb &&
                       (role_master ? (is_chk || final_now) : (is_chk && mism));
    end

    always_ff @(posedge clk) begin
        if (rst || start_det) begin
            state_q <= RX_IDLE;
            final_q <= 1'b0;
            ack_stb <= 1'b0;
            nack    <= 1'b0;
            dma_req <= 1'b0;
            chk_err <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_stb <= verdict.stb;
            nack    <= verdict.nack;
            dma_req <= verdict.chk;
            if (verdict.chk && mism)
                chk_err <= 1'b1;
            if (byte_end)
                final_q <= 1'b0;
            else if (final_set)
                final_q <= 1'b1;
        end
    end

    // R13: acknowledge decisions only after a receive boundary
    a_r13_ack_after_boundary: assert property (@(posedge clk) disable iff (rst)
        ack_stb |-> ($past(byte_end) && !$past(dir_tx)));

    // R10: DMA request only together with an acknowledge strobe
    a_r10_dma_with_ack: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> ack_stb);

    // R9: master-receive always NACKs the check byte
    a_r9_master_nacks_check: assert property (@(posedge clk) disable iff (rst)
        (dma_req && $past(role_master)) |-> nack);

    // R8: error flag is sticky until START
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (chk_err && !start_det) |=> chk_err);

endmodule

// File: rtl/bus_pec_engine.sv
module bus_pec_engine
    import pec_pkg::*;
#(
    parameter crc_t CRC_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             calc_en,
    input  logic [CRC_W-1:0] poly,
    input  logic             start_det,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             byte_end,
    input  logic             dir_tx,
    input  logic             role_master,
    input  logic             chk_req,
    input  logic             dma_eot,
    input  logic             dma_eot_m1,
    input  logic             last_xfer,
    input  logic             arb_lost,
    output logic [CRC_W-1:0] crc_value,
    output logic             crc_valid,
    output logic             chk_load,
    output logic [CRC_W-1:0] chk_byte,
    output logic             chk_err,
    output logic             ack_stb,
    output logic             nack,
    output logic             dma_req
);

    crc_t crc_w;
    logic valid_w;

    pec_crc_core #(.CRC_INIT(CRC_INIT)) u_core (
        .clk       (clk),
        .rst       (rst),
        .start_det (start_det),
        .calc_en   (calc_en),
        .poly      (poly),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .arb_lost  (arb_lost),
        .crc_q     (crc_w),
        .valid_q   (valid_w)
    );

    pec_tx_ctrl u_tx (
        .clk       (clk),
        .rst       (rst),
        .start_det (start_det),
        .calc_en   (calc_en),
        .dir_tx    (dir_tx),
        .chk_req   (chk_req),
        .dma_eot   (dma_eot),
        .byte_end  (byte_end),
        .crc_in    (crc_w),
        .chk_load  (chk_load),
        .chk_byte  (chk_byte)
    );

    pec_rx_ctrl u_rx (
        .clk         (clk),
        .rst         (rst),
        .start_det   (start_det),
        .calc_en     (calc_en),
        .dir_tx      (dir_tx),
        .role_master (role_master),
        .chk_req     (chk_req),
        .dma_eot     (dma_eot),
        .dma_eot_m1  (dma_eot_m1),
        .last_xfer   (last_xfer),
        .byte_end    (byte_end),
        .crc_in      (crc_w),
        .crc_valid   (valid_w),
        .ack_stb     (ack_stb),
        .nack        (nack),
        .chk_err     (chk_err),
        .dma_req     (dma_req)
    );

    assign crc_value = crc_w;
    assign crc_valid = valid_w;

endmodule

// File: tb/bus_pec_engine_tb.sv
module bus_pec_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       calc_en = 1'b1;
    logic [7:0] poly = 8'h07;
    logic       start_det = 1'b0, bit_stb = 1'b0, bit_val = 1'b0, byte_end = 1'b0;
    logic       dir_tx = 1'b0, role_master = 1'b0;
    logic       chk_req = 1'b0, dma_eot = 1'b0, dma_eot_m1 = 1'b0, last_xfer = 1'b0, arb_lost = 1'b0;
    logic [7:0] crc_value, chk_byte;
    logic       crc_valid, chk_load, chk_err, ack_stb, nack, dma_req;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_crc = 8'h00;
    logic       s_ack, s_nack, s_dma, s_load;
    logic [7:0] s_byte;

    always #2 clk = ~clk;

    bus_pec_engine dut_i (
        .clk(clk), .rst(rst), .calc_en(calc_en), .poly(poly), .start_det(start_det),
        .bit_stb(bit_stb), .bit_val(bit_val), .byte_end(byte_end), .dir_tx(dir_tx),
        .role_master(role_master), .chk_req(chk_req), .dma_eot(dma_eot),
        .dma_eot_m1(dma_eot_m1), .last_xfer(last_xfer), .arb_lost(arb_lost),
        .crc_value(crc_value), .crc_valid(crc_valid), .chk_load(chk_load),
        .chk_byte(chk_byte), .chk_err(chk_err), .ack_stb(ack_stb), .nack(nack),
        .dma_req(dma_req)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b, input logic [7:0] p);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--)
            r = (r[7] ^ b[i]) ? ({r[6:0], 1'b0} ^ p) : {r[6:0], 1'b0};
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        exp_crc = 8'h00;
    endtask

    task automatic pulse_arb();
        @(negedge clk); arb_lost = 1'b1;
        @(negedge clk); arb_lost = 1'b0;
    endtask

    // eight bit strobes, side pulses on the fifth bit, then the boundary
    task automatic put_byte(input logic [7:0] b, input logic req, input logic eot, input logic m1);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            bit_stb = 1'b1; bit_val = b[i];
            chk_req = req && (i == 3);
            dma_eot = eot && (i == 3);
            dma_eot_m1 = m1 && (i == 3);
        end
        @(negedge clk);
        bit_stb = 1'b0; chk_req = 1'b0; dma_eot = 1'b0; dma_eot_m1 = 1'b0;
        byte_end = 1'b1;
        @(negedge clk);
        byte_end = 1'b0;
        s_ack = ack_stb; s_nack = nack; s_dma = dma_req; s_load = chk_load; s_byte = chk_byte;
        if (calc_en) exp_crc = ref_crc(exp_crc, b, poly);
    endtask

    task automatic t_reset();
        check("R1 reset crc", crc_value, 8'h00);
        check("R1 reset valid", crc_valid, 1'b1);
        check("R1 reset err", chk_err, 1'b0);
        check("R1 reset outputs", {ack_stb, nack, dma_req, chk_load}, 4'b0);
    endtask

    task automatic t_crc_stream();
        dir_tx = 1'b0; role_master = 1'b0;
        do_start();
        put_byte(8'hA0, 0, 0, 0);
        put_byte(8'h3C, 0, 0, 0);
        check("R2 crc over address and data", crc_value, exp_crc);
        calc_en = 1'b0;
        put_byte(8'hFF, 0, 0, 0);
        check("R3 crc held while disabled", crc_value, exp_crc);
        calc_en = 1'b1;
        put_byte(8'h5A, 0, 0, 0);
        check("R2 crc resumes", crc_value, exp_crc);
    endtask

    task automatic t_poly();
        poly = 8'h31;
        do_start();
        check("R1 start clears crc", crc_value, 8'h00);
        put_byte(8'hA1, 0, 0, 0);
        put_byte(8'h5A, 0, 0, 0);
        check("R4 crc with other polynomial", crc_value, exp_crc);
        poly = 8'h07;
    endtask

    task automatic t_tx_request();
        dir_tx = 1'b1;
        do_start();
        put_byte(8'hA0, 0, 0, 0);
        check("R13 no ack strobe in transmit", s_ack, 1'b0);
        put_byte(8'h11, 0, 0, 0);
        check("R5 no load without request", s_load, 1'b0);
        put_byte(8'h22, 1, 0, 0);
        check("R5 load after requested byte", s_load, 1'b1);
        check("R5 check byte value", s_byte, exp_crc);
        put_byte(8'h55, 0, 0, 0);
        check("R5 load is single", s_load, 1'b0);
    endtask

    task automatic t_tx_eot();
        dir_tx = 1'b1;
        do_start();
        put_byte(8'hA2, 0, 0, 0);
        put_byte(8'h77, 0, 1, 0);
        check("R6 load after end of transfer", s_load, 1'b1);
        check("R6 check byte value", s_byte, exp_crc);
    endtask

    task automatic t_rx_slave_good();
        dir_tx = 1'b0; role_master = 1'b0;
        do_start();
        put_byte(8'hA0, 0, 0, 0);
        put_byte(8'h42, 1, 0, 0);
        check("R13 ack strobe on ordinary byte", s_ack, 1'b1);
        check("R13 ordinary byte acked", s_nack, 1'b0);
        check("R10 no dma request on ordinary byte", s_dma, 1'b0);
        put_byte(exp_crc, 0, 0, 0);
        check("R7 slave acks good check byte", {s_ack, s_nack}, 2'b10);
        check("R7 no error on match", chk_err, 1'b0);
        check("R10 dma request after check byte", s_dma, 1'b1);
    endtask

    task automatic t_rx_slave_bad();
        dir_tx = 1'b0; role_master = 1'b0;
        do_start();
        put_byte(8'hA0, 0, 0, 0);
        put_byte(8'h42, 0, 0, 1);
        put_byte(exp_crc ^ 8'h01, 0, 0, 0);
        check("R8 slave nacks bad check byte", s_nack, 1'b1);
        check("R8 error flag set", chk_err, 1'b1);
        put_byte(8'h10, 0, 0, 0);
        check("R8 error flag sticky", chk_err, 1'b1);
        check("R8 next byte acked", s_nack, 1'b0);
        do_start();
        check("R1 start clears error", chk_err, 1'b0);
    endtask

    task automatic t_rx_master();
        dir_tx = 1'b0; role_master = 1'b1;
        do_start();
        put_byte(8'hA1, 0, 0, 0);
        put_byte(8'h42, 0, 0, 1);
        check("R13 master acks ordinary byte", s_nack, 1'b0);
        put_byte(exp_crc, 0, 0, 0);
        check("R9 master nacks good check byte", s_nack, 1'b1);
        check("R9 no error on match", chk_err, 1'b0);
        check("R10 dma request master", s_dma, 1'b1);
    endtask

    task automatic t_arb();
        dir_tx = 1'b0; role_master = 1'b0;
        do_start();
        put_byte(8'hA0, 0, 0, 0);
        pulse_arb();
        check("R11 crc invalid after arbitration loss", crc_valid, 1'b0);
        put_byte(8'h42, 1, 0, 0);
        put_byte(exp_crc, 0, 0, 0);
        check("R11 invalid crc flags error", chk_err, 1'b1);
        check("R11 invalid crc nacked", s_nack, 1'b1);
        do_start();
        check("R1 start restores validity", crc_valid, 1'b1);
    endtask

    task automatic t_last();
        dir_tx = 1'b0; role_master = 1'b1;
        do_start();
        put_byte(8'hA1, 0, 0, 0);
        last_xfer = 1'b1;
        put_byte(8'h33, 0, 1, 0);
        check("R12 last transfer nacked", s_nack, 1'b1);
        check("R12 no dma request for last byte", s_dma, 1'b0);
        last_xfer = 1'b0;
        do_start();
        put_byte(8'hA1, 0, 0, 0);
        put_byte(8'h33, 0, 1, 0);
        check("R12 without last bit byte acked", s_nack, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_crc_stream();
        t_poly();
        t_tx_request();
        t_tx_eot();
        t_rx_slave_good();
        t_rx_slave_bad();
        t_rx_master();
        t_arb();
        t_last();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule